// File: doc/BRIEF.md
# Embedded Operation Status Toggle Flags

This block produces the two toggle bits that a flash device places on its status reads while an embedded program or erase runs. The primary toggle inverts on every status read while the array is busy with a program, an erase, or a program issued during an erase suspend. The secondary toggle is sector-aware. It inverts only when the read hits a sector in the active erase or suspend set. A host can therefore tell a running erase apart from an erase-suspend-read, and it can find which sectors are being erased.

The surrounding controller supplies the current operating mode, a bit mask of the sectors being erased or suspended, and a read strobe together with the sector index decoded from the read address. Both toggle bits are registered. They show their new values in the cycle after the clock edge that samples the strobe, and the status-read mux forwards them.

Top module: `flash_status_toggle`

## Requirements
- R1: While `rst_n` is low, both `tog_pri` and `tog_sec` read 0, and the secondary forcing flag is cleared.
- R2: A read strobe in program (mode 1), erase (mode 2) or suspend-program (mode 4) inverts `tog_pri`, visible the cycle after the sampling edge.
- R3: A read strobe in idle (mode 0), suspend-read (mode 3) or any unused mode code (5 to 7) leaves `tog_pri` unchanged.
- R4: In erase mode, a read strobe whose sector index has its bit set in `sect_mask` inverts the secondary toggle state.
- R5: In erase mode, a read strobe to a sector whose mask bit is clear leaves the secondary toggle state unchanged, and `tog_sec` returns that unchanged state.
- R6: In suspend-read mode, a read strobe to a sector whose mask bit is set inverts the secondary toggle state while `tog_pri` stays constant.
- R7: In suspend-program mode, a read strobe to a sector whose mask bit is clear makes `tog_sec` read 1. A read strobe to a sector whose mask bit is set returns the stored secondary state without inverting it.
- R8: In a cycle with no read strobe, neither output changes, whatever `mode`, `sect_mask` or `rd_sector` do.
- R9: A sector index at or above `NUM_SECTORS` counts as outside the mask. In erase or suspend-read mode it never inverts the secondary state, and in suspend-program mode it makes `tog_sec` read 1.
- R10: In program, idle and unused modes, read strobes leave the secondary toggle state unchanged. The forcing to 1 applies only to the read it was set by and is released by the next strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Operating mode: 0 idle, 1 program, 2 erase, 3 suspend-read, 4 suspend-program, 5 to 7 treated as idle |
| sect_mask | input | NUM_SECTORS | One bit per sector, set for sectors under erase or suspended |
| rd_stb | input | 1 | One-cycle strobe marking a status read |
| rd_sector | input | SECT_W | Sector index decoded from the read address |
| tog_pri | output | 1 | Primary toggle bit |
| tog_sec | output | 1 | Secondary, sector-aware toggle bit |

## Verification
The bench sweeps every mode code against every sector index, including indices past the last sector, under several mask patterns. Each read result is compared with a bench model. A design that let non-erasing sectors toggle the secondary bit would stop locating the erase target. A design that toggled the primary bit in suspend-read would hide the difference between suspend-read and a live erase. A design that left the forced 1 in place after a suspend-program read would return a stale 1 once the mode moved on. Strobe-free cycles with the inputs changing check that nothing moves without a read. Out-of-range indices check that a non-power-of-two sector count never aliases onto a real mask bit.

// File: rtl/flash_tog_pkg.sv
package flash_tog_pkg;

   typedef enum logic [2:0] {
      MODE_IDLE     = 3'd0,
      MODE_PROG     = 3'd1,
      MODE_ERASE    = 3'd2,
      MODE_SUS_READ = 3'd3,
      MODE_SUS_PROG = 3'd4
   } op_mode_e;

   function automatic int sector_idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/flash_tog_bit.sv
module flash_tog_bit #(
   parameter logic RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flip,
   output logic q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= RESET_VAL;
      else if (flip)
         q <= ~q;
   end

endmodule

// File: rtl/flash_tog_qualify.sv
module flash_tog_qualify
   import flash_tog_pkg::*;
#(
   parameter int NUM_SECTORS = 16,
   parameter int SECT_W      = 4
) (
   input  logic [2:0]             mode,
   input  logic [NUM_SECTORS-1:0] sect_mask,
   input  logic                   rd_stb,
   input  logic [SECT_W-1:0]      rd_sector,
   output logic                   pri_flip,
   output logic                   sec_flip,
   output logic                   force_one
);

   logic hit;
   logic pri_active;
   logic sec_active;
   logic sus_prog;

   // Membership: direct index when every code maps to a sector,
   // otherwise a guarded compare so spare codes never alias.
   generate
      if ((1 << SECT_W) == NUM_SECTORS) begin : g_direct
         assign hit = sect_mask[rd_sector];
      end else begin : g_guarded
         always_comb begin
            hit = 1'b0;
            for (int i = 0; i < NUM_SECTORS; i++) begin
               if (rd_sector == SECT_W'(i))
                  hit = sect_mask[i];
            end
         end
      end
   endgenerate

   always_comb begin
      pri_active = 1'b0;
      sec_active = 1'b0;
      sus_prog   = 1'b0;
      case (op_mode_e'(mode))
         MODE_PROG:     pri_active = 1'b1;
         MODE_ERASE: begin
            pri_active = 1'b1;
            sec_active = 1'b1;
         end
         MODE_SUS_READ: sec_active = 1'b1;
         MODE_SUS_PROG: begin
            pri_active = 1'b1;
            sus_prog   = 1'b1;
         end
         default: ;
      endcase
   end

   assign pri_flip  = rd_stb & pri_active;
   assign sec_flip  = rd_stb & sec_active & hit;
   assign force_one = sus_prog & ~hit;

endmodule

// File: rtl/flash_status_toggle.sv
module flash_status_toggle
   import flash_tog_pkg::*;
#(
   parameter  int NUM_SECTORS = 16,
   localparam int SECT_W      = sector_idx_width(NUM_SECTORS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [2:0]             mode,
   input  logic [NUM_SECTORS-1:0] sect_mask,
   input  logic                   rd_stb,
   input  logic [SECT_W-1:0]      rd_sector,
   output logic                   tog_pri,
   output logic                   tog_sec
);

   generate
      if (NUM_SECTORS < 1) begin : g_bad_sectors
         $error("flash_status_toggle: NUM_SECTORS must be at least 1");
      end
      if ((1 << SECT_W) < NUM_SECTORS) begin : g_bad_width
         $error("flash_status_toggle: sector index too narrow");
      end
   endgenerate

   logic pri_flip;
   logic sec_flip;
   logic force_one;
   logic pri_q;
   logic sec_q;
   logic force_q;

   flash_tog_qualify #(
      .NUM_SECTORS (NUM_SECTORS),
      .SECT_W      (SECT_W)
   ) u_qualify (
      .mode      (mode),
      .sect_mask (sect_mask),
      .rd_stb    (rd_stb),
      .rd_sector (rd_sector),
      .pri_flip  (pri_flip),
      .sec_flip  (sec_flip),
      .force_one (force_one)
   );

   flash_tog_bit #(.RESET_VAL(1'b0)) u_pri (
      .clk   (clk),
      .rst_n (rst_n),
      .flip  (pri_flip),
      .q     (pri_q)
   );

   flash_tog_bit #(.RESET_VAL(1'b0)) u_sec (
      .clk   (clk),
      .rst_n (rst_n),
      .flip  (sec_flip),
      .q     (sec_q)
   );

   // The forced-one flag is reloaded by every read strobe.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         force_q <= 1'b0;
      else if (rd_stb)
         force_q <= force_one;
   end

   assign tog_pri = pri_q;
   assign tog_sec = sec_q | force_q;

endmodule

// File: rtl/flash_status_toggle_chk.sv
module flash_status_toggle_chk #(
   parameter int NUM_SECTORS = 16,
   parameter int SECT_W      = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [2:0]             mode,
   input logic [NUM_SECTORS-1:0] sect_mask,
   input logic                   rd_stb,
   input logic [SECT_W-1:0]      rd_sector,
   input logic                   tog_pri,
   input logic                   tog_sec,
   input logic                   sec_state
);

   logic member;
   logic busy_pri;
   logic sec_mode;

   always_comb begin
      member = 1'b0;
      for (int i = 0; i < NUM_SECTORS; i++)
         if (int'(rd_sector) == i && sect_mask[i])
            member = 1'b1;
   end

   assign busy_pri = (mode == 3'd1) || (mode == 3'd2) || (mode == 3'd4);
   assign sec_mode = (mode == 3'd2) || (mode == 3'd3);

   assert_reset_R1: assert property (@(posedge clk)
      !rst_n |=> (!tog_pri && !tog_sec));

   assert_pri_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && busy_pri) |=> (tog_pri != $past(tog_pri)));

   assert_pri_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !busy_pri) |=> $stable(tog_pri));

   assert_sec_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && sec_mode && member) |=> (sec_state != $past(sec_state)));

   assert_sec_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !(sec_mode && member)) |=> $stable(sec_state));

   assert_force_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && mode == 3'd4 && !member) |=> tog_sec);

   assert_no_read_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> ($stable(tog_pri) && $stable(tog_sec)));

endmodule

bind flash_status_toggle flash_status_toggle_chk #(
   .NUM_SECTORS (NUM_SECTORS),
   .SECT_W      (SECT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode      (mode),
   .sect_mask (sect_mask),
   .rd_stb    (rd_stb),
   .rd_sector (rd_sector),
   .tog_pri   (tog_pri),
   .tog_sec   (tog_sec),
   .sec_state (sec_q)
);

// File: tb/flash_status_toggle_bench.sv
module flash_status_toggle_bench;

   localparam int N  = 6;
   localparam int SW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    mode = 3'd0;
   logic [N-1:0]  sect_mask = '0;
   logic          rd_stb = 1'b0;
   logic [SW-1:0] rd_sector = '0;
   logic          tog_pri;
   logic          tog_sec;

   int  tests = 0;
   int  fails = 0;
   bit  done = 1'b0;
   bit  m_pri = 1'b0;
   bit  m_sec = 1'b0;
   bit  m_force = 1'b0;

   always #10 clk = ~clk;

   flash_status_toggle #(.NUM_SECTORS(N)) u_flash_status_toggle (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .sect_mask (sect_mask),
      .rd_stb    (rd_stb),
      .rd_sector (rd_sector),
      .tog_pri   (tog_pri),
      .tog_sec   (tog_sec)
   );

   task automatic check(input string req, input logic act, input logic exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   function automatic bit in_mask(input logic [N-1:0] m, input int s);
      return (s < N) ? m[s] : 1'b0;
   endfunction

   task automatic do_read(input int md, input int s);
      bit    mem;
      string tp;
      string ts;
      mem = in_mask(sect_mask, s);
      @(negedge clk);
      mode      = 3'(md);
      rd_sector = SW'(s);
      rd_stb    = 1'b1;
      if (md == 1 || md == 2 || md == 4) begin
         m_pri = ~m_pri;
         tp = "R2";
      end else
         tp = (md == 3) ? "R3/R6" : "R3";
      if ((md == 2 || md == 3) && mem)
         m_sec = ~m_sec;
      m_force = (md == 4) && !mem;
      if (s >= N && md >= 2 && md <= 4) ts = "R9";
      else if (md == 2) ts = mem ? "R4" : "R5";
      else if (md == 3) ts = mem ? "R6" : "R10";
      else if (md == 4) ts = "R7";
      else ts = "R10";
      @(negedge clk);
      rd_stb = 1'b0;
      check(tp, tog_pri, m_pri);
      check(ts, tog_sec, m_sec | m_force);
   endtask

   task automatic quiet_cycle(input int md, input int s);
      @(negedge clk);
      mode      = 3'(md);
      rd_sector = SW'(s);
      sect_mask = ~sect_mask;
      rd_stb    = 1'b0;
      @(negedge clk);
      sect_mask = ~sect_mask;
      check("R8", tog_pri, m_pri);
      check("R8", tog_sec, m_sec | m_force);
   endtask

   initial begin
      logic [N-1:0] masks [4];
      masks[0] = 6'b000000;
      masks[1] = 6'b101101;
      masks[2] = 6'b111111;
      masks[3] = 6'b010010;
      repeat (3) @(negedge clk);
      check("R1", tog_pri, 1'b0);
      check("R1", tog_sec, 1'b0);
      rst_n = 1'b1;
      for (int k = 0; k < 4; k++) begin
         sect_mask = masks[k];
         for (int md = 0; md < 8; md++) begin
            for (int s = 0; s < 8; s++) begin
               do_read(md, s);
               do_read(md, s);
               if (s == 3) quiet_cycle((md + 1) % 8, 7 - s);
            end
         end
      end
      // Forced one released by a following strobe in another mode
      sect_mask = 6'b000001;
      do_read(4, 2);
      do_read(0, 2);
      do_read(4, 0);
      do_read(1, 5);
      // Reset returns both bits to zero
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1", tog_pri, 1'b0);
      check("R1", tog_sec, 1'b0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #4000000;
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule